// File: doc/BRIEF.md
# Translation Configuration Decode Sequencer

This block turns a stream's 16-word entry into a stage-1 translation configuration. A `start` pulse captures the entry. The block then checks the entry and decides between four outcomes: translate, silent abort, bypass, or a malformed-entry fault. When the entry asks for translation, the block reads the 16-word context descriptor it points to, one word at a time, over a simple request/response read port. It then checks the descriptor and builds the configuration.

The configuration holds:
- the output address width in bits,
- the address-space identifier,
- the two top-byte-ignore bits,
- the fault-recording flag,
- for each of the two translation tables: a disable flag, the input size field, the log2 of the granule, and the table base address.

Any rejection ends the sequence at once, with no further reads, and reports one fault code. `done` pulses for one cycle when the result is ready. The outcome, the fault code and the configuration stay on the outputs until the next run reports a new result.

Top module: `xcs_seq`

## Requirements
- R1: If entry word0 bit 0 is clear, the block reports outcome 3 (fault) with fault code 1 (bad entry) and issues no read.
- R2: If the entry is valid and word0 bit 3 (the top bit of the 3-bit mode field in word0 bits [3:1]) is clear, the block reports outcome 1 (abort) with fault code 0 and issues no read.
- R3: A valid entry whose mode field equals 4 gives outcome 2 (bypass) with fault code 0 and issues no read.
- R4: A valid entry is rejected with outcome 3 and fault code 1 if any of these hold: mode bit 1 (word0 bit 2) is set, entry word1 bits [31:27] are nonzero, or entry word2 bit 27 is set.
- R5: An accepted entry (mode 5) starts exactly 16 reads. They go to byte addresses A+4k for k = 0..15, where A = {entry word1[15:0], entry word0[31:6], 6'b0}. At most one read is outstanding. `rd_req` and `rd_addr` hold steady until `rd_valid`.
- R6: A read response with `rd_err` set gives outcome 3 with fault code 2 (descriptor fetch), and no further read is requested.
- R7: The descriptor gets outcome 3 with fault code 3 (bad descriptor) if any of these hold: word0 bit 31 (valid) is clear; word1 bit 9 (64-bit format) is clear; word1 bit 14 is clear; any of word1 bits 12, 11 or 10 is set.
- R8: Output size code word1[2:0] maps 0..5 to 32, 36, 40, 42, 44 and 48 bits. Codes 6 and 7 count as the largest size. The result is clamped to the size of code MAX_OAS_CODE (default 4, i.e. 44 bits).
- R9: Table i (i = 0 or 1) is disabled when descriptor word0 bit 16i+14 is set. A disabled table is not checked and reports disable = 1 with zero size, granule and base. An enabled table needs a size field (word0 bits [16i+5:16i]) from 16 to 39.
- R10: The granule code sits in word0 bits [16i+7:16i+6]. Table 0 maps codes 0, 1, 2, 3 to 12, 16, 14, invalid. Table 1 maps them to invalid, 14, 12, 16. An enabled table is accepted only with granule 12 or 16 and word0 bit 15 clear.
- R11: The base of table i is {word 2i+3 bits [18:0], word 2i+2 bits [31:4], 4'b0}. If any base bit at or above the output width is set, the descriptor is rejected with fault code 3.
- R12: On success (outcome 0), the identifier is descriptor word1 bits [31:16], top-byte-ignore is word1 bits [7:6], and the record flag is word1 bit 13.
- R13: `done` is high for exactly one cycle per run. A `start` during a run is ignored. After reset, `done` and `rd_req` are low and outcome and fault read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run; entry captured this cycle when idle |
| entry_words | input | 512 | Stream entry, word k in bits [32k+31:32k] |
| rd_req | output | 1 | Descriptor word read request |
| rd_addr | output | 48 | Byte address of requested word |
| rd_valid | input | 1 | Read response present this cycle |
| rd_data | input | 32 | Read response data |
| rd_err | input | 1 | Read response carries an error |
| done | output | 1 | One-cycle result strobe |
| outcome | output | 2 | 0 translate, 1 abort, 2 bypass, 3 fault |
| fault | output | 2 | 0 none, 1 bad entry, 2 fetch error, 3 bad descriptor |
| oas_bits | output | 6 | Output address width in bits |
| asid | output | 16 | Address-space identifier |
| tbi | output | 2 | Top-byte-ignore bits |
| rec_faults | output | 1 | Record translation faults flag |
| tt_dis | output | 2 | Per-table disable flag, bit i for table i |
| tt_tsz | output | 12 | Per-table size field, 6 bits per table |
| tt_gran | output | 10 | Per-table log2 granule, 5 bits per table |
| tt_base | output | 102 | Per-table base address, 51 bits per table |

## Verification
Two events can land in the same cycle: the last descriptor word returning and the read error that ends the fetch. The bench injects the error on word 15, where the fetch would otherwise move on to descriptor decode. It checks that the fetch-error code is reported and that the descriptor, which would decode cleanly, is never taken. A second coincidence is a new `start` arriving while a fetch is in flight. The bench pulses `start` with an abort entry mid-fetch and requires the original translation result and a single `done`.

// File: rtl/xcs_pkg.sv
package xcs_pkg;

    localparam int WORD_W = 32;
    localparam int ADDR_W = 48;
    localparam int BASE_W = 51;

    typedef enum logic [1:0] {
        OUT_XLATE  = 2'd0,
        OUT_ABORT  = 2'd1,
        OUT_BYPASS = 2'd2,
        OUT_FAULT  = 2'd3
    } outcome_e;

    typedef enum logic [1:0] {
        FLT_NONE      = 2'd0,
        FLT_BAD_ENTRY = 2'd1,
        FLT_CD_FETCH  = 2'd2,
        FLT_BAD_CD    = 2'd3
    } fault_e;

    typedef struct packed {
        logic              dis;
        logic [5:0]        tsz;
        logic [4:0]        gran;
        logic [BASE_W-1:0] base;
    } tt_cfg_t;

    typedef struct packed {
        logic [5:0]   oas;
        logic [15:0]  asid;
        logic [1:0]   tbi;
        logic         rec;
        tt_cfg_t [1:0] tt;
    } xcfg_t;

    // Width in bits selected by an output size code; reserved codes give the largest.
    function automatic logic [5:0] size_bits(input logic [2:0] code);
        case (code)
            3'd0:    size_bits = 6'd32;
            3'd1:    size_bits = 6'd36;
            3'd2:    size_bits = 6'd40;
            3'd3:    size_bits = 6'd42;
            3'd4:    size_bits = 6'd44;
            default: size_bits = 6'd48;
        endcase
    endfunction

    // log2 granule; the code meaning depends on the table; 0 marks invalid.
    function automatic logic [4:0] granule_log(input logic [1:0] code, input logic tbl);
        case (code)
            2'd0:    granule_log = tbl ? 5'd0  : 5'd12;
            2'd1:    granule_log = tbl ? 5'd14 : 5'd16;
            2'd2:    granule_log = tbl ? 5'd12 : 5'd14;
            default: granule_log = tbl ? 5'd16 : 5'd0;
        endcase
    endfunction

endpackage

// File: rtl/xcs_entry_dec.sv
module xcs_entry_dec
    import xcs_pkg::*;
(
    input  logic [WORD_W-1:0] w0,
    input  logic [WORD_W-1:0] w1,
    input  logic [WORD_W-1:0] w2,
    output outcome_e          kind,
    output logic [ADDR_W-1:0] cd_addr
);
    logic [2:0] mode;
    assign mode    = w0[3:1];
    assign cd_addr = {w1[15:0], w0[31:6], 6'b0};

    always_comb begin
        if (!w0[0])
            kind = OUT_FAULT;
        else if (!mode[2])
            kind = OUT_ABORT;
        else if (mode == 3'd4)
            kind = OUT_BYPASS;
        else if (mode[1] || (|w1[31:27]) || w2[27])
            kind = OUT_FAULT;
        else
            kind = OUT_XLATE;
    end
endmodule

// File: rtl/xcs_tt_dec.sv
module xcs_tt_dec
    import xcs_pkg::*;
#(
    parameter int TBL = 0
) (
    input  logic [WORD_W-1:0] w0,
    input  logic [WORD_W-1:0] w_lo,
    input  logic [WORD_W-1:0] w_hi,
    input  logic [5:0]        oas,
    output tt_cfg_t           cfg,
    output logic              bad
);
    localparam int OFS = 16 * TBL;

    logic              off;
    logic [5:0]        tsz;
    logic [4:0]        gran;
    logic [BASE_W-1:0] base;
    logic              size_ng, gran_ng, base_ng;

    assign off  = w0[OFS + 14];
    assign tsz  = w0[OFS +: 6];
    assign gran = granule_log(w0[OFS + 6 +: 2], TBL != 0);
    assign base = {w_hi[18:0], w_lo[31:4], 4'b0};

    assign size_ng = (tsz < 6'd16) || (tsz > 6'd39);
    assign gran_ng = !((gran == 5'd12) || (gran == 5'd16)) || w0[15];
    assign base_ng = (base >> oas) != '0;
    assign bad     = !off && (size_ng || gran_ng || base_ng);

    always_comb begin
        cfg     = '0;
        cfg.dis = off;
        if (!off) begin
            cfg.tsz  = tsz;
            cfg.gran = gran;
            cfg.base = base;
        end
    end
endmodule

// File: rtl/xcs_cd_dec.sv
module xcs_cd_dec
    import xcs_pkg::*;
#(
    parameter int MAX_OAS_CODE = 4
) (
    input  logic [7:0][WORD_W-1:0] cd_w,
    output xcfg_t                  cfg,
    output logic                   bad
);
    logic [5:0]    cap, raw, oas;
    tt_cfg_t [1:0] tt_v;
    logic [1:0]    tt_bad;
    logic          flag_ng;

    assign cap = size_bits(3'(MAX_OAS_CODE));
    assign raw = size_bits(cd_w[1][2:0]);
    assign oas = (raw < cap) ? raw : cap;

    assign flag_ng = !cd_w[0][31] || !cd_w[1][9] || !cd_w[1][14]
                   || cd_w[1][12] || cd_w[1][11] || cd_w[1][10];

    for (genvar g = 0; g < 2; g++) begin : g_tt
        xcs_tt_dec #(.TBL(g)) u_tt (
            .w0   (cd_w[0]),
            .w_lo (cd_w[2*g + 2]),
            .w_hi (cd_w[2*g + 3]),
            .oas  (oas),
            .cfg  (tt_v[g]),
            .bad  (tt_bad[g])
        );
    end

    assign bad = flag_ng || (|tt_bad);

    always_comb begin
        cfg      = '0;
        cfg.oas  = oas;
        cfg.asid = cd_w[1][31:16];
        cfg.tbi  = cd_w[1][7:6];
        cfg.rec  = cd_w[1][13];
        cfg.tt   = tt_v;
    end
endmodule

// File: rtl/xcs_seq.sv
module xcs_seq
    import xcs_pkg::*;
#(
    parameter int CD_WORDS     = 16,
    parameter int ENTRY_WORDS  = 16,
    parameter int MAX_OAS_CODE = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          start,
    input  logic [ENTRY_WORDS*32-1:0]     entry_words,
    output logic                          rd_req,
    output logic [47:0]                   rd_addr,
    input  logic                          rd_valid,
    input  logic [31:0]                   rd_data,
    input  logic                          rd_err,
    output logic                          done,
    output logic [1:0]                    outcome,
    output logic [1:0]                    fault,
    output logic [5:0]                    oas_bits,
    output logic [15:0]                   asid,
    output logic [1:0]                    tbi,
    output logic                          rec_faults,
    output logic [1:0]                    tt_dis,
    output logic [11:0]                   tt_tsz,
    output logic [9:0]                    tt_gran,
    output logic [101:0]                  tt_base
);
    localparam int KEEP   = 8;
    localparam int KEEP_W = $clog2(KEEP);
    localparam int IDX_W  = $clog2(CD_WORDS);

    typedef enum logic [2:0] {S_IDLE, S_ENTRY, S_FETCH, S_DESC, S_DONE} state_e;

    state_e                   state_q;
    logic [2:0][WORD_W-1:0]   ent_q;
    logic [7:0][WORD_W-1:0]   cd_q;
    logic [IDX_W-1:0]         idx_q;
    logic [ADDR_W-1:0]        cd_base_q;
    outcome_e                 outcome_q;
    fault_e                   fault_q;
    xcfg_t                    cfg_q;

    outcome_e                 e_kind;
    logic [ADDR_W-1:0]        e_addr;
    xcfg_t                    d_cfg;
    logic                     d_bad;

    xcs_entry_dec u_ent (
        .w0      (ent_q[0]),
        .w1      (ent_q[1]),
        .w2      (ent_q[2]),
        .kind    (e_kind),
        .cd_addr (e_addr)
    );

    xcs_cd_dec #(.MAX_OAS_CODE(MAX_OAS_CODE)) u_cd (
        .cd_w (cd_q),
        .cfg  (d_cfg),
        .bad  (d_bad)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= S_IDLE;
            ent_q     <= '0;
            cd_q      <= '0;
            idx_q     <= '0;
            cd_base_q <= '0;
            outcome_q <= OUT_XLATE;
            fault_q   <= FLT_NONE;
            cfg_q     <= '0;
        end else begin
            case (state_q)
                S_IDLE: begin
                    if (start) begin
                        ent_q   <= entry_words[3*WORD_W-1:0];
                        state_q <= S_ENTRY;
                    end
                end
                S_ENTRY: begin
                    if (e_kind == OUT_XLATE) begin
                        cd_base_q <= e_addr;
                        idx_q     <= '0;
                        state_q   <= S_FETCH;
                    end else begin
                        outcome_q <= e_kind;
                        fault_q   <= (e_kind == OUT_FAULT) ? FLT_BAD_ENTRY : FLT_NONE;
                        cfg_q     <= '0;
                        state_q   <= S_DONE;
                    end
                end
                S_FETCH: begin
                    if (rd_valid) begin
                        if (rd_err) begin
                            outcome_q <= OUT_FAULT;
                            fault_q   <= FLT_CD_FETCH;
                            cfg_q     <= '0;
                            state_q   <= S_DONE;
                        end else begin
                            if (int'(idx_q) < KEEP)
                                cd_q[idx_q[KEEP_W-1:0]] <= rd_data;
                            if (int'(idx_q) == CD_WORDS - 1)
                                state_q <= S_DESC;
                            else
                                idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                S_DESC: begin
                    outcome_q <= d_bad ? OUT_FAULT : OUT_XLATE;
                    fault_q   <= d_bad ? FLT_BAD_CD : FLT_NONE;
                    cfg_q     <= d_bad ? '0 : d_cfg;
                    state_q   <= S_DONE;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign rd_req     = (state_q == S_FETCH);
    assign rd_addr    = cd_base_q + ADDR_W'({idx_q, 2'b00});
    assign done       = (state_q == S_DONE);
    assign outcome    = outcome_q;
    assign fault      = fault_q;
    assign oas_bits   = cfg_q.oas;
    assign asid       = cfg_q.asid;
    assign tbi        = cfg_q.tbi;
    assign rec_faults = cfg_q.rec;

    for (genvar g = 0; g < 2; g++) begin : g_out
        assign tt_dis[g]               = cfg_q.tt[g].dis;
        assign tt_tsz[6*g +: 6]        = cfg_q.tt[g].tsz;
        assign tt_gran[5*g +: 5]       = cfg_q.tt[g].gran;
        assign tt_base[BASE_W*g +: BASE_W] = cfg_q.tt[g].base;
    end
endmodule

// File: rtl/xcs_seq_chk.sv
module xcs_seq_chk
    import xcs_pkg::*;
#(
    parameter int MAX_OAS_CODE = 4
) (
    input logic        clk,
    input logic        rst,
    input logic        rd_req,
    input logic [47:0] rd_addr,
    input logic        rd_valid,
    input logic        rd_err,
    input logic        done,
    input logic [1:0]  outcome,
    input logic [1:0]  fault,
    input logic [5:0]  oas_bits
);
    logic [5:0] cap;
    assign cap = size_bits(3'(MAX_OAS_CODE));

    p_done_pulse_r13: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_req_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));

    p_addr_step_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_req && rd_valid && !rd_err) |=> (!rd_req || (rd_addr == $past(rd_addr) + 48'd4)));

    p_stop_on_err_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_req && rd_valid && rd_err) |=> !rd_req);

    p_fault_code_r1: assert property (@(posedge clk) disable iff (rst)
        done |-> ((outcome == 2'd3) == (fault != 2'd0)));

    p_oas_cap_r8: assert property (@(posedge clk) disable iff (rst)
        (done && outcome == 2'd0) |-> (oas_bits <= cap));

    p_no_req_at_done_r13: assert property (@(posedge clk) disable iff (rst)
        done |-> !rd_req);
endmodule

bind xcs_seq xcs_seq_chk #(.MAX_OAS_CODE(MAX_OAS_CODE)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .rd_req   (rd_req),
    .rd_addr  (rd_addr),
    .rd_valid (rd_valid),
    .rd_err   (rd_err),
    .done     (done),
    .outcome  (outcome),
    .fault    (fault),
    .oas_bits (oas_bits)
);

// File: tb/xcs_seq_bench.sv
module xcs_seq_bench;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [511:0] entry_words = '0;
    logic         rd_req;
    logic [47:0]  rd_addr;
    logic         rd_valid = 1'b0;
    logic [31:0]  rd_data = '0;
    logic         rd_err = 1'b0;
    logic         done;
    logic [1:0]   outcome, fault;
    logic [5:0]   oas_bits;
    logic [15:0]  asid;
    logic [1:0]   tbi;
    logic         rec_faults;
    logic [1:0]   tt_dis;
    logic [11:0]  tt_tsz;
    logic [9:0]   tt_gran;
    logic [101:0] tt_base;

    xcs_seq u_xcs_seq (
        .clk(clk), .rst(rst), .start(start), .entry_words(entry_words),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid),
        .rd_data(rd_data), .rd_err(rd_err), .done(done),
        .outcome(outcome), .fault(fault), .oas_bits(oas_bits), .asid(asid),
        .tbi(tbi), .rec_faults(rec_faults), .tt_dis(tt_dis), .tt_tsz(tt_tsz),
        .tt_gran(tt_gran), .tt_base(tt_base)
    );

    always #10 clk = ~clk;   // 50 MHz

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    // descriptor memory model
    logic [31:0] mem [16];
    logic [47:0] addr_log [32];
    int          beats = 0;
    int          err_idx = -1;
    logic        slow = 1'b0;
    logic        tog = 1'b0;

    always @(negedge clk) begin
        rd_valid = 1'b0;
        rd_err   = 1'b0;
        rd_data  = '0;
        if (rd_req) begin
            tog = ~tog;
            if (!slow || tog) begin
                rd_valid = 1'b1;
                if (beats < 32) addr_log[beats] = rd_addr;
                if (int'(rd_addr[5:2]) == err_idx) rd_err = 1'b1;
                else rd_data = mem[rd_addr[5:2]];
                beats++;
            end
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog R13: actual cycles %0d expected completion", cycles);
            finish_run();
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // descriptor fields
    logic [5:0]  c_tsz [2];
    logic [1:0]  c_tg [2];
    logic        c_off [2];
    logic [31:0] c_blo [2];
    logic [18:0] c_bhi [2];
    logic        c_endi, c_valid, c_aa64, c_hd, c_ha, c_s, c_r, c_a;
    logic [2:0]  c_ips;
    logic [1:0]  c_tbi;
    logic [15:0] c_asid;

    task automatic cd_default();
        c_tsz[0] = 6'd25; c_tg[0] = 2'd0; c_off[0] = 1'b0;
        c_tsz[1] = 6'd25; c_tg[1] = 2'd2; c_off[1] = 1'b0;
        c_blo[0] = 32'h3456_7890; c_bhi[0] = 19'h12;
        c_blo[1] = 32'hCAFE_F00F; c_bhi[1] = 19'hA5;
        c_endi = 0; c_valid = 1; c_aa64 = 1; c_hd = 0; c_ha = 0; c_s = 0;
        c_r = 1; c_a = 1; c_ips = 3'd2; c_tbi = 2'b01; c_asid = 16'hBEEF;
    endtask

    task automatic cd_load();
        for (int k = 0; k < 16; k++) mem[k] = 32'h0BAD_0000 + 32'(k);
        mem[0] = {c_valid, c_off[1], 6'b0, c_tg[1], c_tsz[1],
                  c_endi, c_off[0], 6'b0, c_tg[0], c_tsz[0]};
        mem[1] = {c_asid, 1'b0, c_a, c_r, c_s, c_ha, c_hd, c_aa64, 1'b0, c_tbi, 3'b0, c_ips};
        mem[2] = c_blo[0]; mem[3] = {13'h1FFF & 13'h0, c_bhi[0]} | 32'hFFF8_0000;
        mem[4] = c_blo[1]; mem[5] = {13'h0, c_bhi[1]} | 32'hFFF8_0000;
    endtask

    localparam logic [47:0] CD_A = 48'h00AB_CDEF_1240;

    function automatic logic [511:0] mk_entry(input logic v, input logic [2:0] mode,
                                              input logic [4:0] cdmax, input logic stall,
                                              input logic [47:0] a);
        logic [511:0] e = '0;
        e[31:0]  = {a[31:6], 2'b00, mode, v};
        e[63:32] = {cdmax, 11'h2AA, a[47:32]};
        e[95:64] = 32'(stall) << 27;
        return e;
    endfunction

    task automatic run(input logic [511:0] e);
        int t = 0;
        beats = 0;
        @(negedge clk);
        entry_words = e;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && t < 2000) begin
            @(negedge clk);
            t++;
        end
    endtask

    task automatic chk_res(input string req, input logic [1:0] o, input logic [1:0] f);
        check({req, " done"}, 64'(done), 64'd1);
        check({req, " outcome"}, 64'(outcome), 64'(o));
        check({req, " fault"}, 64'(fault), 64'(f));
    endtask

    task automatic t_reset();
        check("R13 reset done", 64'(done), 0);
        check("R13 reset rd_req", 64'(rd_req), 0);
        check("R13 reset outcome", 64'(outcome), 0);
        check("R13 reset fault", 64'(fault), 0);
    endtask

    task automatic t_entry_paths();
        run(mk_entry(0, 3'd5, 0, 0, CD_A)); chk_res("R1 invalid", 3, 1);
        check("R1 no reads", 64'(beats), 0);
        run(mk_entry(1, 3'd3, 0, 0, CD_A)); chk_res("R2 abort mode3", 1, 0);
        check("R2 no reads", 64'(beats), 0);
        run(mk_entry(1, 3'd0, 0, 0, CD_A)); chk_res("R2 abort mode0", 1, 0);
        run(mk_entry(1, 3'd4, 0, 0, CD_A)); chk_res("R3 bypass", 2, 0);
        check("R3 no reads", 64'(beats), 0);
        run(mk_entry(1, 3'd6, 0, 0, CD_A)); chk_res("R4 stage2", 3, 1);
        run(mk_entry(1, 3'd7, 0, 0, CD_A)); chk_res("R4 stage2 both", 3, 1);
        run(mk_entry(1, 3'd5, 5'd1, 0, CD_A)); chk_res("R4 multi ctx", 3, 1);
        run(mk_entry(1, 3'd5, 0, 1, CD_A)); chk_res("R4 stall", 3, 1);
        check("R4 no reads", 64'(beats), 0);
    endtask

    task automatic t_good(input logic use_slow);
        cd_default(); cd_load();
        slow = use_slow;
        run(mk_entry(1, 3'd5, 0, 0, CD_A));
        slow = 0;
        chk_res("R5 good", 0, 0);
        check("R5 read count", 64'(beats), 16);
        for (int k = 0; k < 16; k++)
            check("R5 read addr", 64'(addr_log[k]), 64'(CD_A + 48'(4 * k)));
        check("R8 oas 40", 64'(oas_bits), 40);
        check("R12 asid", 64'(asid), 64'h BEEF);
        check("R12 tbi", 64'(tbi), 1);
        check("R12 rec", 64'(rec_faults), 1);
        check("R9 dis", 64'(tt_dis), 0);
        check("R9 tsz", 64'(tt_tsz), {52'd0, 6'd25, 6'd25});
        check("R10 gran", 64'(tt_gran), {54'd0, 5'd12, 5'd12});
        check("R11 base0", 64'(tt_base[50:0]), 64'h12_3456_7890);
        check("R11 base1 bit39", 64'(tt_base[101:51]), 64'hA5_CAFE_F000);
        @(negedge clk);
        check("R13 done one cycle", 64'(done), 0);
    endtask

    task automatic t_fetch_err();
        cd_default(); cd_load();
        err_idx = 15;
        run(mk_entry(1, 3'd5, 0, 0, CD_A));
        chk_res("R6 err last word", 3, 2);
        check("R6 reads to last", 64'(beats), 16);
        err_idx = 3;
        run(mk_entry(1, 3'd5, 0, 0, CD_A));
        chk_res("R6 err word3", 3, 2);
        check("R6 stop after err", 64'(beats), 4);
        err_idx = -1;
    endtask

    task automatic cd_try(input string req, input logic [1:0] o, input logic [1:0] f);
        cd_load();
        run(mk_entry(1, 3'd5, 0, 0, CD_A));
        chk_res(req, o, f);
    endtask

    task automatic t_bad_cd();
        cd_default(); c_valid = 0; cd_try("R7 valid clear", 3, 3);
        cd_default(); c_aa64 = 0;  cd_try("R7 fmt clear", 3, 3);
        cd_default(); c_a = 0;     cd_try("R7 bit14 clear", 3, 3);
        cd_default(); c_s = 1;     cd_try("R7 bit12 set", 3, 3);
        cd_default(); c_ha = 1;    cd_try("R7 bit11 set", 3, 3);
        cd_default(); c_hd = 1;    cd_try("R7 bit10 set", 3, 3);
    endtask

    task automatic t_oas();
        cd_default(); c_bhi[0] = 0; c_bhi[1] = 0;
        c_ips = 3'd5; cd_try("R8 code5", 0, 0);
        check("R8 clamp 44", 64'(oas_bits), 44);
        c_ips = 3'd7; cd_try("R8 code7", 0, 0);
        check("R8 reserved max", 64'(oas_bits), 44);
        c_ips = 3'd0; cd_try("R8 code0", 0, 0);
        check("R8 32 bits", 64'(oas_bits), 32);
        c_ips = 3'd3; cd_try("R8 code3", 0, 0);
        check("R8 42 bits", 64'(oas_bits), 42);
    endtask

    task automatic t_tables();
        cd_default(); c_off[0] = 1; c_tsz[0] = 6'd5; cd_try("R9 tt0 off", 0, 0);
        check("R9 dis flags", 64'(tt_dis), 1);
        check("R9 tt0 zero base", 64'(tt_base[50:0]), 0);
        check("R9 tt0 zero tsz", 64'(tt_tsz[5:0]), 0);
        cd_default(); c_tsz[0] = 6'd15; cd_try("R9 tsz15", 3, 3);
        cd_default(); c_tsz[0] = 6'd16; cd_try("R9 tsz16", 0, 0);
        cd_default(); c_tsz[1] = 6'd39; cd_try("R9 tsz39", 0, 0);
        cd_default(); c_tsz[1] = 6'd40; cd_try("R9 tsz40", 3, 3);
        cd_default(); c_tg[1] = 2'd0; cd_try("R10 tt1 code0", 3, 3);
        cd_default(); c_tg[1] = 2'd3; cd_try("R10 tt1 code3", 0, 0);
        check("R10 tt1 gran16", 64'(tt_gran[9:5]), 16);
        cd_default(); c_tg[0] = 2'd1; cd_try("R10 tt0 code1", 0, 0);
        check("R10 tt0 gran16", 64'(tt_gran[4:0]), 16);
        cd_default(); c_tg[0] = 2'd2; cd_try("R10 tt0 code2", 3, 3);
        cd_default(); c_tg[1] = 2'd1; cd_try("R10 tt1 code1", 3, 3);
        cd_default(); c_endi = 1; cd_try("R10 endian", 3, 3);
        cd_default(); c_endi = 1; c_off[0] = 1; c_off[1] = 1;
        cd_try("R10 endian both off", 0, 0);
    endtask

    task automatic t_base();
        cd_default(); c_bhi[1] = 19'h1A5; cd_try("R11 bit40 over", 3, 3);
        cd_default(); c_bhi[0] = 19'h100; cd_try("R11 tt0 bit40", 3, 3);
        cd_default(); c_bhi[0] = 19'h80; cd_try("R11 tt0 bit39", 0, 0);
    endtask

    task automatic t_busy_start();
        int t = 0;
        int dones = 0;
        cd_default(); cd_load();
        beats = 0;
        @(negedge clk);
        entry_words = mk_entry(1, 3'd5, 0, 0, CD_A);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        entry_words = mk_entry(1, 3'd0, 0, 0, CD_A);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (t < 40) begin
            if (done) begin
                dones++;
                if (dones == 1) chk_res("R13 busy start ignored", 0, 0);
            end
            @(negedge clk);
            t++;
        end
        check("R13 single done", 64'(dones), 1);
    endtask

    initial begin
        cd_default(); cd_load();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_entry_paths();
        t_good(1'b0);
        t_good(1'b1);
        t_fetch_err();
        t_bad_cd();
        t_oas();
        t_tables();
        t_base();
        t_busy_start();
        finish_run();
    end
endmodule